// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the 256-byte configuration space of one device function. A request carries a 24-bit configuration address holding a bus number, a device/function number and a register offset. The block claims only requests whose bus and device/function fields match its own parameters. Claimed reads return byte, halfword or word data one cycle later. Claimed writes update the storage under a set of per-register rules.

A full, aligned word written to a region base register, or to the expansion ROM register, is masked to the region's size alignment. The ROM register also keeps its enable bit. Every other write is applied byte by byte. Each byte is checked against a protection map chosen by the header-type byte, so identity, header, subsystem and base-register bytes cannot be changed through the byte path. Reserved command and status bits are stored as zero. Any write that reaches the command register raises a one-cycle notification, so a downstream region decoder can rebuild its mappings.

Top module: `cfg_space_regfile`

## Requirements
- R1: A request is claimed only when address bits 23:16 equal BUS_NUM and bits 15:8 equal DEVFN. An unclaimed read returns 32'hFFFFFFFF, and an unclaimed write changes no stored byte.
- R2: The width code on `req_len` is 0 for a byte, 1 for a halfword and 2 for a word. A read answers on the next cycle with `rd_valid` high. Data is little-endian, with the byte at the offset in bits 7:0, and byte and halfword reads are zero-extended.
- R3: These requests are invalid: a word access at an offset above 0xFC, a halfword access at an offset above 0xFE, and any access with width code 3. An invalid read returns all ones, and an invalid write is ignored.
- R4: After reset, the word at 0x00 holds ID_WORD, the byte at 0x0E holds HDR_TYPE, the word at 0x2C holds SUBSYS_WORD, and every other byte is zero.
- R5: A word write to a base register i (offset 0x10+4i, i below the header's register count) stores the data ANDed with the inverse of (2^BAR_SZLOG[i] − 1).
- R6: A word write to the ROM register stores the data ANDed with the inverse of (2^ROM_SZLOG − 1), with data bit 0 kept. The ROM register is at 0x30 when bits 6:0 of byte 0x0E are 0, and at 0x38 when they are 1.
- R7: For a header whose type field (bits 6:0 of byte 0x0E) is 0, these bytes are read-only through the byte path: 0x00–0x03, 0x08–0x0B, 0x0E, 0x3D, 0x2C–0x2F, the base-register bytes 0x10–0x27 and the ROM bytes 0x30–0x33. All other bytes are writable.
- R8: In a multi-byte write through the byte path, each byte is handled on its own, so the writable bytes of the transfer are stored and the read-only ones are kept.
- R9: For a header whose type field is 1, there are two base registers (0x10–0x17), and the ROM bytes are 0x38–0x3B. The bytes 0x18–0x2B and 0x30–0x33 are writable, and the identity, subsystem, 0x0E and 0x3D bytes stay read-only.
- R10: A write to byte 0x05 stores only bits 2:0. A write to byte 0x06 stores the data with bits 2:0 cleared.
- R11: `cmd_changed` pulses for exactly one cycle, on the cycle after a claimed, valid write whose byte range covers 0x04 or 0x05. It stays low after every other request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 24 | Bus [23:16], device/function [15:8], offset [7:0] |
| req_len | input | 2 | Width code: 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data, little-endian |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| cmd_changed | output | 1 | One-cycle notice that the command register was written |

## Verification
Two functions can act in the same transfer: the reserved-bit masking of the command and status bytes, and the command-change notice. The bench provokes this with a word write of all ones at 0x04. It then judges both the masked word read back and the notice pulse from that single write. A second overlap is a halfword write at 0x03. That write lands partly on a read-only identity byte and partly on the command byte, so the bench checks both that the identity byte is unchanged and that the notice still fires. Both header types are exercised on separate instances that share one request bus, which also shows that only the matching instance claims each request.

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile #(
  parameter logic [7:0]  BUS_NUM     = 8'h02,
  parameter logic [7:0]  DEVFN       = 8'h28,
  parameter logic [31:0] ID_WORD     = 32'h1234_ABCD,
  parameter logic [31:0] SUBSYS_WORD = 32'h5678_9A0B,
  parameter logic [7:0]  HDR_TYPE    = 8'h00,
  parameter int          NBAR        = 6,
  parameter logic [NBAR*5-1:0] BAR_SZLOG = {5'd12, 5'd12, 5'd12, 5'd12, 5'd4, 5'd8},
  parameter logic [4:0]  ROM_SZLOG   = 5'd11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [23:0] req_addr,
  input  logic [1:0]  req_len,
  input  logic [31:0] req_wdata,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        cmd_changed
);
  localparam int NBYTES = 256;
  localparam logic [8:0] BAR_END0 = 9'(16 + 4 * NBAR);
  localparam logic [8:0] BAR_END1 = 9'd24;

  logic [7:0] mem [NBYTES];

  logic [7:0] off;
  logic       hit, lim_ok, bridge, reg_path, is_rom;
  logic [2:0] nb;
  logic [8:0] bar_end, end9;
  logic [7:0] rom_off;
  logic [4:0] sz;
  logic [31:0] reg_val, rd_word, wmask;

  assign off     = req_addr[7:0];
  assign hit     = req_valid && req_addr[23:16] == BUS_NUM && req_addr[15:8] == DEVFN;
  assign nb      = (req_len == 2'd0) ? 3'd1 : (req_len == 2'd1) ? 3'd2 : (req_len == 2'd2) ? 3'd4 : 3'd0;
  assign lim_ok  = (req_len == 2'd0) || (req_len == 2'd1 && off <= 8'hFE) ||
                   (req_len == 2'd2 && off <= 8'hFC);
  assign bridge  = mem[8'h0E][6:0] == 7'd1;
  assign rom_off = bridge ? 8'h38 : 8'h30;
  assign bar_end = bridge ? BAR_END1 : BAR_END0;
  assign end9    = {1'b0, off} + {6'd0, nb};
  assign is_rom  = off == rom_off;
  assign reg_path = req_len == 2'd2 &&
                    ((off[1:0] == 2'b00 && off >= 8'h10 && {1'b0, off} < bar_end) || is_rom);

  always_comb begin
    sz = ROM_SZLOG;
    for (int k = 0; k < NBAR; k++)
      if (!is_rom && off == 8'(16 + 4 * k)) sz = BAR_SZLOG[5*k +: 5];
  end

  assign reg_val = (req_wdata & ~((32'd1 << sz) - 32'd1)) | (is_rom ? {31'd0, req_wdata[0]} : 32'd0);
  assign rd_word = {mem[off + 8'd3], mem[off + 8'd2], mem[off + 8'd1], mem[off]};
  assign wmask   = (req_len == 2'd0) ? 32'h0000_00FF : (req_len == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;

  function automatic logic ro_byte(input logic [7:0] a, input logic br);
    logic [8:0] be;
    logic [7:0] ro;
    be = br ? BAR_END1 : BAR_END0;
    ro = br ? 8'h38 : 8'h30;
    return a <= 8'h03 || (a >= 8'h08 && a <= 8'h0B) || a == 8'h0E || a == 8'h3D ||
           (a >= 8'h2C && a <= 8'h2F) || (a >= 8'h10 && {1'b0, a} < be) ||
           (a >= ro && a <= ro + 8'd3);
  endfunction

  function automatic logic [7:0] keep_bits(input logic [7:0] a);
    return (a == 8'h05) ? 8'h07 : (a == 8'h06) ? 8'hF8 : 8'hFF;
  endfunction

  function automatic logic [7:0] init_byte(input int k);
    if (k < 4) return ID_WORD[8*k +: 8];
    if (k == 14) return HDR_TYPE;
    if (k >= 44 && k < 48) return SUBSYS_WORD[8*(k-44) +: 8];
    return 8'h00;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NBYTES; k++) mem[k] <= init_byte(k);
    end else if (hit && req_write && lim_ok) begin
      for (int i = 0; i < 4; i++) begin
        if (reg_path)
          mem[off + 8'(i)] <= reg_val[8*i +: 8];
        else if (3'(i) < nb && !ro_byte(off + 8'(i), bridge))
          mem[off + 8'(i)] <= req_wdata[8*i +: 8] & keep_bits(off + 8'(i));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid    <= 1'b0;
      rd_data     <= 32'hFFFF_FFFF;
      cmd_changed <= 1'b0;
    end else begin
      rd_valid    <= req_valid && !req_write;
      cmd_changed <= hit && req_write && lim_ok && off <= 8'h05 && end9 > 9'h004;
      if (req_valid && !req_write)
        rd_data <= (hit && lim_ok) ? (rd_word & wmask) : 32'hFFFF_FFFF;
    end
  end
endmodule

// File: rtl/cfg_space_regfile_chk.sv
module cfg_space_regfile_chk #(
  parameter logic [7:0] BUS_NUM = 8'h02,
  parameter logic [7:0] DEVFN   = 8'h28
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [23:0] req_addr,
  input logic [1:0]  req_len,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        cmd_changed
);
  logic mine, rd_req;
  assign mine   = req_valid && req_addr[23:16] == BUS_NUM && req_addr[15:8] == DEVFN;
  assign rd_req = req_valid && !req_write;

  p_miss_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !mine) |=> rd_data == 32'hFFFF_FFFF);

  p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  p_byte_zext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && mine && req_len == 2'd0) |=> rd_data[31:8] == 24'd0);

  p_word_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && req_len == 2'd2 && req_addr[7:0] > 8'hFC) |=> rd_data == 32'hFFFF_FFFF);

  p_cmd_notice_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mine && req_write && req_len == 2'd0 && req_addr[7:0] == 8'h04) |=> cmd_changed);

  p_cmd_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_changed |-> $past(req_valid && req_write));

  p_cmd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_changed && !(mine && req_write)) |=> !cmd_changed);
endmodule

bind cfg_space_regfile cfg_space_regfile_chk #(.BUS_NUM(BUS_NUM), .DEVFN(DEVFN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_len(req_len), .rd_valid(rd_valid), .rd_data(rd_data),
  .cmd_changed(cmd_changed)
);

// File: tb/cfg_space_regfile_tb.sv
module cfg_space_regfile_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [23:0] req_addr = 0;
  logic [1:0]  req_len = 0;
  logic [31:0] req_wdata = 0;
  logic rv0, rv1, cm0, cm1;
  logic [31:0] rd0, rd1;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cfg_space_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rd_valid(rv0), .rd_data(rd0), .cmd_changed(cm0));

  cfg_space_regfile #(.DEVFN(8'h30), .HDR_TYPE(8'h81)) u_dut_brg (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rd_valid(rv1), .rd_data(rd1), .cmd_changed(cm1));

  function automatic logic [23:0] a0(input logic [7:0] o); return {8'h02, 8'h28, o}; endfunction
  function automatic logic [23:0] a1(input logic [7:0] o); return {8'h02, 8'h30, o}; endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic [23:0] a, input logic [1:0] l, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_len = l; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic t_reset();
    op(0, a0(8'h00), 2, 0); chk("R4 id", rd0, 32'h1234_ABCD); chk("R2 valid", {31'd0, rv0}, 1);
    op(0, a0(8'h2C), 2, 0); chk("R4 subsys", rd0, 32'h5678_9A0B);
    op(0, a0(8'h0E), 0, 0); chk("R4 hdr", rd0, 32'h0);
    op(0, a1(8'h0E), 0, 0); chk("R4 hdr bridge", rd1, 32'h81);
    op(0, a0(8'h04), 2, 0); chk("R4 zero", rd0, 32'h0);
  endtask

  task automatic t_endian();
    op(0, a0(8'h01), 1, 0); chk("R2 half", rd0, 32'h0000_34AB);
    op(0, a0(8'h03), 0, 0); chk("R2 byte", rd0, 32'h12);
    @(negedge clk); chk("R2 idle", {31'd0, rv0}, 0);
  endtask

  task automatic t_claim();
    op(0, {8'h03, 8'h28, 8'h00}, 2, 0); chk("R1 bus miss", rd0, 32'hFFFF_FFFF);
    op(0, a0(8'h00), 2, 0); chk("R1 other inst", rd1, 32'hFFFF_FFFF);
    op(1, {8'h02, 8'h29, 8'h3C}, 0, 32'h55);
    op(0, a0(8'h3C), 0, 0); chk("R1 miss write", rd0, 32'h0);
  endtask

  task automatic t_limits();
    op(0, a0(8'hFD), 2, 0); chk("R3 word fd", rd0, 32'hFFFF_FFFF);
    op(0, a0(8'hFF), 1, 0); chk("R3 half ff", rd0, 32'hFFFF_FFFF);
    op(0, a0(8'hFC), 2, 0); chk("R3 word fc", rd0, 32'h0);
    op(0, a0(8'hFF), 0, 0); chk("R3 byte ff", rd0, 32'h0);
    op(0, a0(8'h00), 3, 0); chk("R3 len3", rd0, 32'hFFFF_FFFF);
    op(1, a0(8'hFD), 2, 32'hAABB_CCDD);
    op(0, a0(8'hFD), 0, 0); chk("R3 write ignored", rd0, 32'h0);
  endtask

  task automatic t_bar();
    op(1, a0(8'h10), 2, 32'hFFFF_FFFF); op(0, a0(8'h10), 2, 0); chk("R5 bar0", rd0, 32'hFFFF_FF00);
    op(1, a0(8'h14), 2, 32'hFFFF_FFFF); op(0, a0(8'h14), 2, 0); chk("R5 bar1", rd0, 32'hFFFF_FFF0);
    op(1, a0(8'h24), 2, 32'h1234_5678); op(0, a0(8'h24), 2, 0); chk("R5 bar5", rd0, 32'h1234_5000);
    op(1, a0(8'h10), 0, 32'h0);         op(0, a0(8'h10), 2, 0); chk("R7 bar byte", rd0, 32'hFFFF_FF00);
  endtask

  task automatic t_rom();
    op(1, a0(8'h30), 2, 32'hFFFF_FFFF); op(0, a0(8'h30), 2, 0); chk("R6 rom ones", rd0, 32'hFFFF_F801);
    op(1, a0(8'h30), 2, 32'h1234_5678); op(0, a0(8'h30), 2, 0); chk("R6 rom off", rd0, 32'h1234_5000);
    op(1, a0(8'h30), 2, 32'h1234_567F); op(0, a0(8'h30), 2, 0); chk("R6 rom en", rd0, 32'h1234_5001);
    op(1, a0(8'h31), 0, 32'h00);        op(0, a0(8'h30), 2, 0); chk("R7 rom byte", rd0, 32'h1234_5001);
  endtask

  task automatic t_protect();
    op(1, a0(8'h00), 2, 32'h0);  op(0, a0(8'h00), 2, 0); chk("R7 id ro", rd0, 32'h1234_ABCD);
    op(1, a0(8'h2C), 1, 32'h0);  op(0, a0(8'h2C), 2, 0); chk("R7 subsys ro", rd0, 32'h5678_9A0B);
    op(1, a0(8'h3D), 0, 32'h7);  op(0, a0(8'h3D), 0, 0); chk("R7 pin ro", rd0, 32'h0);
    op(1, a0(8'h3C), 0, 32'h5A); op(0, a0(8'h3C), 0, 0); chk("R7 line rw", rd0, 32'h5A);
    op(1, a0(8'h0D), 1, 32'hEEFF); op(0, a0(8'h0C), 2, 0); chk("R8 partial", rd0, 32'h0000_FF00);
  endtask

  task automatic t_reserved_notice();
    op(1, a0(8'h05), 0, 32'hFF); chk("R11 byte05", {31'd0, cm0}, 1);
    op(0, a0(8'h05), 0, 0); chk("R10 cmd hi", rd0, 32'h07);
    op(1, a0(8'h06), 0, 32'hFF); chk("R11 byte06 none", {31'd0, cm0}, 0);
    op(0, a0(8'h06), 0, 0); chk("R10 status lo", rd0, 32'hF8);
    op(1, a0(8'h04), 2, 32'hFFFF_FFFF); chk("R11 word04", {31'd0, cm0}, 1);
    @(negedge clk); chk("R11 one cycle", {31'd0, cm0}, 0);
    op(0, a0(8'h04), 2, 0); chk("R10 word", rd0, 32'hFFF8_07FF);
    chk("R11 read none", {31'd0, cm0}, 0);
    op(1, a0(8'h03), 1, 32'h0000_0000); chk("R11 half03", {31'd0, cm0}, 1);
    op(0, a0(8'h00), 2, 0); chk("R8 half03 id kept", rd0, 32'h1234_ABCD);
    op(0, a0(8'h04), 0, 0); chk("R8 half03 cmd", rd0, 32'h0);
    op(1, a0(8'h00), 2, 32'h0); chk("R11 word00 none", {31'd0, cm0}, 0);
    op(1, {8'h02, 8'h29, 8'h04}, 0, 32'h1); chk("R11 miss none", {31'd0, cm0}, 0);
    op(1, a0(8'h04), 0, 32'h2); chk("R11 byte04", {31'd0, cm0}, 1);
    chk("R11 other inst", {31'd0, cm1}, 0);
  endtask

  task automatic t_bridge();
    op(1, a1(8'h10), 2, 32'hFFFF_FFFF); op(0, a1(8'h10), 2, 0); chk("R9 bar0", rd1, 32'hFFFF_FF00);
    op(1, a1(8'h18), 2, 32'hFFFF_FFFF); op(0, a1(8'h18), 2, 0); chk("R9 18 rw", rd1, 32'hFFFF_FFFF);
    op(1, a1(8'h38), 2, 32'hFFFF_FFFF); op(0, a1(8'h38), 2, 0); chk("R6 bridge rom", rd1, 32'hFFFF_F801);
    op(1, a1(8'h30), 0, 32'h77);        op(0, a1(8'h30), 0, 0); chk("R9 30 rw", rd1, 32'h77);
    op(1, a1(8'h38), 0, 32'h00);        op(0, a1(8'h38), 2, 0); chk("R9 rom byte ro", rd1, 32'hFFFF_F801);
    op(1, a1(8'h2C), 0, 32'h00);        op(0, a1(8'h2C), 2, 0); chk("R9 subsys ro", rd1, 32'h5678_9A0B);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_endian();
    t_claim();
    t_limits();
    t_bar();
    t_rom();
    t_protect();
    t_reserved_notice();
    t_bridge();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule